// File: doc/BRIEF.md
# Port-Shadow Bank Mapper

This block listens to an 8-bit CPU bus and keeps its own copies of a parallel port's data register, direction register and control register. It can only see the write cycles that software issues to the real port, and it cannot sample the real pins. From the copies it works out the level each port pin would show. A pin configured as an input reads high because the board has pull-up resistors on those pins.

When the expansion switch is on and emulated pin 4 is low, a window opens over CPU addresses $4000–$7FFF. Any bus access that falls in this window turns off the host's internal memory and goes instead to one 16 KB bank of a 512 KB external RAM. Five of the emulated pins choose the bank. Software sets up the port exactly as it would for a native memory expansion, and the block follows along silently.

Top module: `pia_bank_shadow`

## Requirements
- R1: After reset the shadow control, direction and data registers are all zero. Every emulated pin therefore reads 1, and no access asserts `xram_cs` until software reconfigures the port.
- R2: A write cycle (`bus_valid`=1, `bus_we`=1) to `CTRL_ADDR` ($D303) stores data bit 2 as the select flag. The other bits of that write have no effect.
- R3: A write cycle to `DATA_ADDR` ($D301) loads the shadow data register when the select flag is 1. It loads the shadow direction register when the select flag is 0.
- R4: Emulated pin n is 1 when direction bit n is 0 (input, pulled up). When direction bit n is 1 (output), pin n equals data bit n.
- R5: The window is active only when `xram_enable`=1 and emulated pin 4 is 0.
- R6: `xram_cs` and `int_mem_disable` are both 1 exactly when `bus_valid`=1, the window is active, and `bus_addr` lies in $4000–$7FFF. In every other case both are 0.
- R7: `xram_addr` equals {pin7, pin6, pin5, pin3, pin2, bus_addr[13:0]}, with pin 2 as bank bit 0.
- R8: Read cycles, and writes to any address other than the two port addresses, leave the shadow state unchanged.
- R9: A write updates the shadow state on the rising clock edge where the write is qualified. The window outputs follow the address and the new state combinationally, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A CPU bus cycle is in progress this clock |
| bus_we | input | 1 | The current cycle is a write |
| bus_addr | input | 16 | CPU address |
| bus_data | input | 8 | CPU write data |
| xram_enable | input | 1 | Expansion switch |
| int_mem_disable | output | 1 | Turns off internal memory for this access |
| xram_cs | output | 1 | Select for the external RAM |
| xram_addr | output | 19 | External RAM address |

## Verification
The assertions assume that `bus_valid`, `bus_we`, `bus_addr`, `bus_data` and `xram_enable` are stable across each rising clock edge. They also assume that a write means exactly one qualified strobe per cycle. The bench keeps within these assumptions by changing every input only at falling edges, and by holding each bus cycle for one full clock period. Random traffic mixes port writes, reads to the port addresses, writes to unrelated addresses and window probes, and the expansion switch is toggled during the run. Directed cases cover the window boundaries, the lowest and highest banks, and an all-input port.

// File: rtl/pia_bank_shadow.sv
module pia_bank_shadow #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          WIN_BITS  = 14,
  parameter int          BANK_W    = 5,
  parameter logic [15:0] DATA_ADDR = 16'hD301,
  parameter logic [15:0] CTRL_ADDR = 16'hD303,
  parameter int          SEL_BIT   = 2,
  parameter int          EN_PIN    = 4,
  parameter logic [1:0]  WIN_TAG   = 2'b01
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_data,
  input  logic                         xram_enable,
  output logic                         int_mem_disable,
  output logic                         xram_cs,
  output logic [BANK_W+WIN_BITS-1:0]   xram_addr
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic              sel_q;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] pins;
  logic [BANK_W-1:0] bank;
  logic              wr, wr_data, wr_ctrl, win_on, in_win;

  assign wr      = bus_valid && bus_we;
  assign wr_data = wr && (bus_addr == DATA_ADDR[ADDR_W-1:0]);
  assign wr_ctrl = wr && (bus_addr == CTRL_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) sel_q <= bus_data[SEL_BIT];
      if (wr_data && sel_q)  data_q <= bus_data;
      if (wr_data && !sel_q) dir_q  <= bus_data;
    end
  end

  assign pins   = ~dir_q | data_q;
  assign bank   = {pins[7], pins[6], pins[5], pins[3], pins[2]};
  assign win_on = xram_enable && !pins[EN_PIN];
  assign in_win = bus_addr[ADDR_W-1:WIN_BITS] == WIN_TAG[TAG_W-1:0];

  assign xram_cs         = bus_valid && win_on && in_win;
  assign int_mem_disable = xram_cs;
  assign xram_addr       = {bank, bus_addr[WIN_BITS-1:0]};
endmodule

// File: rtl/pia_bank_shadow_chk.sv
module pia_bank_shadow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_data,
  input logic        xram_enable,
  input logic        int_mem_disable,
  input logic        xram_cs,
  input logic [18:0] xram_addr,
  input logic        sel_q,
  input logic [7:0]  dir_q,
  input logic [7:0]  data_q
);
  // R6
  cs_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_cs |-> (bus_valid && bus_addr[15:14] == 2'b01));
  // R5
  switch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xram_enable |-> !xram_cs);
  // R6
  disable_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_mem_disable == xram_cs);
  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_addr[13:0] == bus_addr[13:0]);
  // R8
  read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && $past(rst_n)) |=> ($stable(dir_q) && $stable(data_q) && $stable(sel_q)));
  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'hD301 && !sel_q) |=> (dir_q == $past(bus_data)));
  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'hD303) |=> (sel_q == $past(bus_data[2])));
endmodule

bind pia_bank_shadow pia_bank_shadow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_data(bus_data), .xram_enable(xram_enable),
  .int_mem_disable(int_mem_disable), .xram_cs(xram_cs), .xram_addr(xram_addr),
  .sel_q(sel_q), .dir_q(dir_q), .data_q(data_q)
);

// File: tb/pia_bank_shadow_bench.sv
module pia_bank_shadow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        xram_enable = 1'b0;
  logic        int_mem_disable, xram_cs;
  logic [18:0] xram_addr;

  int checks = 0;
  int errors = 0;
  logic       m_sel;
  logic [7:0] m_dir, m_data;
  bit         done = 0;

  always #4 clk = ~clk;

  pia_bank_shadow u_pia_bank_shadow (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_data(bus_data), .xram_enable(xram_enable),
    .int_mem_disable(int_mem_disable), .xram_cs(xram_cs), .xram_addr(xram_addr));

  function automatic logic [7:0] exp_pins();
    return ~m_dir | m_data;
  endfunction

  function automatic logic exp_cs(input logic [15:0] a);
    logic [7:0] p = exp_pins();
    return xram_enable && !p[4] && a[15:14] == 2'b01;
  endfunction

  function automatic logic [18:0] exp_addr(input logic [15:0] a);
    logic [7:0] p = exp_pins();
    return {p[7], p[6], p[5], p[3], p[2], a[13:0]};
  endfunction

  task automatic cycle(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_data = d;
    @(posedge clk);
    if (we && a == 16'hD303) m_sel = d[2];
    else if (we && a == 16'hD301) begin
      if (m_sel) m_data = d; else m_dir = d;
    end
  endtask

  task automatic probe(input logic [15:0] a, input string tag);
    logic ec;
    logic [18:0] ea;
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    ec = exp_cs(a);
    ea = exp_addr(a);
    checks++;
    if (xram_cs !== ec || int_mem_disable !== ec) begin
      errors++;
      $display("FAIL %s cs addr=%h actual=%b/%b expected=%b", tag, a, xram_cs, int_mem_disable, ec);
    end
    checks++;
    if (xram_addr !== ea) begin
      errors++;
      $display("FAIL %s xram_addr addr=%h actual=%h expected=%h", tag, a, xram_addr, ea);
    end
  endtask

  task automatic idle_probe(input logic [15:0] a);
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; bus_addr = a;
    #1;
    checks++;
    if (xram_cs !== 1'b0 || int_mem_disable !== 1'b0) begin
      errors++;
      $display("FAIL R6 idle cycle actual=%b/%b expected=0", xram_cs, int_mem_disable);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_sel = 0; m_dir = 0; m_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; xram_enable = 1'b1;
    // R1: pins high after reset, window closed
    probe(16'h4000, "R1");
    probe(16'h7FFF, "R1");
    // R3 R4: select direction, all outputs, data zero -> bank 0 open
    cycle(1'b1, 16'hD303, 8'h00);
    cycle(1'b1, 16'hD301, 8'hFF);
    // R9: effect visible the cycle right after the write
    probe(16'h4123, "R9");
    cycle(1'b1, 16'hD303, 8'hFB);   // R2: only bit 2 matters -> select stays 0
    cycle(1'b1, 16'hD301, 8'hFF);
    probe(16'h5000, "R2");
    cycle(1'b1, 16'hD303, 8'h04);
    cycle(1'b1, 16'hD301, 8'h00);
    probe(16'h4000, "R7");          // bank 0
    probe(16'h3FFF, "R6");
    probe(16'h8000, "R6");
    cycle(1'b1, 16'hD301, 8'hEC);
    probe(16'h7FFF, "R7");          // bank 31
    // R8: read and foreign write ignored
    cycle(1'b0, 16'hD301, 8'h10);
    cycle(1'b1, 16'hD302, 8'h10);
    cycle(1'b0, 16'hD303, 8'h00);
    probe(16'h6ABC, "R8");
    // R5: switch off closes window
    @(negedge clk); xram_enable = 1'b0;
    probe(16'h4000, "R5");
    @(negedge clk); xram_enable = 1'b1;
    idle_probe(16'h4000);
    // R4 R5: all-input port disables window
    cycle(1'b1, 16'hD303, 8'h00);
    cycle(1'b1, 16'hD301, 8'h00);
    probe(16'h4000, "R4");
    cycle(1'b1, 16'hD301, 8'h10);
    probe(16'h4000, "R4");

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      logic [15:0] a = 16'($urandom);
      case (k)
        0: cycle(1'b1, 16'hD303, d);
        1, 2: cycle(1'b1, 16'hD301, d);
        3: cycle(1'b0, ($urandom_range(0, 1) != 0) ? 16'hD301 : 16'hD303, d);
        4: cycle(1'b1, (a == 16'hD301 || a == 16'hD303) ? 16'h0000 : a, d);
        5: begin @(negedge clk); xram_enable = ($urandom_range(0, 3) != 0); end
        6: idle_probe(a);
        default: probe({($urandom_range(0, 2) != 0) ? 2'b01 : a[15:14], a[13:0]}, "R6/R7/R8");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule